// File: doc/BRIEF.md
# Two-Channel Gate-Enable Pulse Decoder

This block sits on the receiving end of a two-channel pulse-coded link. Every channel carries two kinds of one-cycle strobe. An "on" strobe asks for a high gate-enable level, and an "off" strobe asks for a low one. For each channel the block holds the last requested level in a bistable latch and drives it onto a gate-enable output. The sending side repeats its strobes at regular intervals. A per-channel watchdog therefore treats a long silence as a dead input and pulls that channel low.

Three conditions force the outputs low:
- an output-side supply that is not yet declared good, which arrives as a digital input;
- the watchdog expiring on a channel;
- a cross-channel interlock, when it is selected, which stops two channels from being enabled together.

After reset, every output is low until a strobe requests otherwise.

Top module: `pd_rx_top`

## Requirements
- R1: An "on" strobe alone on a channel makes that channel's latched level high from the next clock edge. The level then holds until a later strobe changes it.
- R2: An "off" strobe alone on a channel makes that channel's output low after the next clock edge.
- R3: When "on" and "off" arrive on one channel in the same cycle, the latched level keeps its previous value.
- R4: Suppose a channel's last strobe was taken at edge e and the watchdog limit is TIMEOUT_CYC cycles. The output then stays valid through edge e+TIMEOUT_CYC-1 and is low from edge e+TIMEOUT_CYC onward. At that same edge the latched level is cleared.
- R5: Any strobe on a channel, of either kind, restarts that channel's watchdog count from zero. The channels time out independently.
- R6: After a timeout, the first "on" strobe restores a high output on the next edge. A simultaneous on/off pair after a timeout leaves the output low.
- R7: While reset is asserted, and after its release until a strobe arrives, every output is low.
- R8: supply_ok is sampled by one register. When it was low at the previous edge, every output is low, whatever the strobes.
- R9: The latch keeps tracking strobes during supply lockout. One edge after supply_ok returns high, the outputs show the latched levels again.
- R10: With mode_excl high, the outputs are all forced low whenever more than one channel would be high. A single high channel, or none, passes through unchanged.
- R11: With mode_excl low, every combination of channel levels, all high included, reaches the outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| supply_ok | input | 1 | Output-side supply declared good (1) or in lockout (0) |
| mode_excl | input | 1 | 1 selects the cross-channel interlock, 0 lets channels overlap |
| set_pulse | input | NCH | Per-channel "on" strobe, one bit per channel (bit 0 = channel A) |
| clr_pulse | input | NCH | Per-channel "off" strobe, one bit per channel |
| drive | output | NCH | Gate-enable levels, bit 0 = channel A |

## Verification
Four rules are checked on every cycle by the assertions:
- the supply lockout forces the outputs low;
- with the interlock selected, no two enables are high together;
- a lone "off" strobe lowers its output;
- a lone "on" strobe raises its output when neither the lockout nor the interlock intervenes.

The watchdog window cannot be observed on a single edge, so only the bench's scenarios can show it:
- the exact cycle on which a silent channel drops;
- the restart of the count by a fresh strobe;
- recovery after a timeout.

The same holds for the hold-on-conflict rule and the release of the supply lockout.

// File: rtl/pd_pkg.sv
package pd_pkg;

  // Classification of the strobes seen on one channel in one cycle.
  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_ON   = 2'd1,
    EV_OFF  = 2'd2,
    EV_BOTH = 2'd3
  } pd_ev_e;

  function automatic pd_ev_e pd_classify(input logic on_s, input logic off_s);
    pd_ev_e ev;
    case ({off_s, on_s})
      2'b01:   ev = EV_ON;
      2'b10:   ev = EV_OFF;
      2'b11:   ev = EV_BOTH;
      default: ev = EV_NONE;
    endcase
    return ev;
  endfunction

endpackage

// File: rtl/pd_chan.sv
// One channel: bistable level latch plus loss-of-strobe watchdog.
module pd_chan #(
  parameter int unsigned TIMEOUT_CYC = 600,
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on_i,
  input  logic off_i,
  output logic level_o,
  output logic expired_o
);
  import pd_pkg::*;

  localparam logic [CW-1:0] LIM    = CW'(TIMEOUT_CYC);
  localparam logic [CW-1:0] LIM_M1 = CW'(TIMEOUT_CYC - 1);

  pd_ev_e          ev;
  logic            hit;
  logic            lvl_r, lvl_n;
  logic [CW-1:0]   cnt_r, cnt_n;
  logic            cnt_en;

  // next-state
  always_comb begin
    ev     = pd_classify(on_i, off_i);
    hit    = (ev != EV_NONE);
    cnt_en = hit || (cnt_r != LIM);
    cnt_n  = hit ? '0 : cnt_r + 1'b1;
    case (ev)
      EV_ON:   lvl_n = 1'b1;
      EV_OFF:  lvl_n = 1'b0;
      EV_BOTH: lvl_n = lvl_r;
      default: lvl_n = (cnt_r >= LIM_M1) ? 1'b0 : lvl_r;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_r <= 1'b0;
      cnt_r <= LIM;
    end else begin
      lvl_r <= lvl_n;
      if (cnt_en) cnt_r <= cnt_n;
    end
  end

  assign level_o   = lvl_r;
  assign expired_o = (cnt_r == LIM);

endmodule

// File: rtl/pd_gate.sv
// Output gating: watchdog, supply lockout and optional interlock.
module pd_gate #(
  parameter int unsigned NCH = 2
) (
  input  logic [NCH-1:0] level_i,
  input  logic [NCH-1:0] expired_i,
  input  logic           pwr_ok_i,
  input  logic           excl_i,
  output logic [NCH-1:0] drive_o
);
  logic [NCH-1:0] pass;

  always_comb begin
    pass = level_i & ~expired_i & {NCH{pwr_ok_i}};
    if (excl_i && ($countones(pass) > 1))
      drive_o = '0;
    else
      drive_o = pass;
  end

endmodule

// File: rtl/pd_rx_top.sv
module pd_rx_top #(
  parameter int unsigned NCH         = 2,
  parameter int unsigned TIMEOUT_CYC = 600
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           supply_ok,
  input  logic           mode_excl,
  input  logic [NCH-1:0] set_pulse,
  input  logic [NCH-1:0] clr_pulse,
  output logic [NCH-1:0] drive
);
  logic [1:0]     rst_sync;
  logic           rst_n_i;
  logic           pwr_q;
  logic [NCH-1:0] lvl;
  logic [NCH-1:0] expd;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_n_i = rst_sync[1];

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) pwr_q <= 1'b0;
    else          pwr_q <= supply_ok;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    pd_chan #(.TIMEOUT_CYC(TIMEOUT_CYC)) chan_i (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .on_i     (set_pulse[g]),
      .off_i    (clr_pulse[g]),
      .level_o  (lvl[g]),
      .expired_o(expd[g])
    );
  end

  pd_gate #(.NCH(NCH)) gate_i (
    .level_i  (lvl),
    .expired_i(expd),
    .pwr_ok_i (pwr_q),
    .excl_i   (mode_excl),
    .drive_o  (drive)
  );

endmodule

// File: rtl/pd_rx_chk.sv
module pd_rx_chk #(
  parameter int unsigned NCH = 2
) (
  input logic           clk,
  input logic           rst_ni,
  input logic           supply_ok,
  input logic           mode_excl,
  input logic [NCH-1:0] set_pulse,
  input logic [NCH-1:0] clr_pulse,
  input logic [NCH-1:0] drive
);

  // R8
  lockout_low_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !$past(supply_ok) |-> (drive == '0));

  // R10
  excl_single_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    mode_excl |-> ($countones(drive) <= 1));

  for (genvar g = 0; g < NCH; g++) begin : g_c
    // R2
    off_lowers_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      (clr_pulse[g] && !set_pulse[g]) |=> !drive[g]);

    // R1
    on_raises_chk: assert property (@(posedge clk) disable iff (!rst_ni)
      (set_pulse[g] && !clr_pulse[g] && supply_ok) |=> (drive[g] || mode_excl));
  end

endmodule

bind pd_rx_top pd_rx_chk #(.NCH(NCH)) chk_i (
  .clk      (clk),
  .rst_ni   (rst_n_i),
  .supply_ok(supply_ok),
  .mode_excl(mode_excl),
  .set_pulse(set_pulse),
  .clr_pulse(clr_pulse),
  .drive    (drive)
);

// File: tb/pd_rx_top_tb_top.sv
`timescale 1ns/1ps
module pd_rx_top_tb_top;
  localparam int unsigned TO = 40;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       supply_ok;
  logic       mode_excl;
  logic [1:0] set_pulse;
  logic [1:0] clr_pulse;
  logic [1:0] drive;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done  = 1'b0;

  always #2.5 clk = ~clk;

  pd_rx_top #(.NCH(2), .TIMEOUT_CYC(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .mode_excl(mode_excl),
    .set_pulse(set_pulse), .clr_pulse(clr_pulse), .drive(drive)
  );

  // {excl, set[1:0], clr[1:0], expected drive[1:0]}, applied in sequence
  localparam logic [6:0] VEC [10] = '{
    {1'b1, 2'b01, 2'b00, 2'b01},  // R1 ch A on
    {1'b1, 2'b10, 2'b01, 2'b10},  // R1 R2 B on, A off
    {1'b1, 2'b01, 2'b00, 2'b00},  // R10 both latched, interlock
    {1'b0, 2'b00, 2'b00, 2'b11},  // R11 interlock off, overlap passes
    {1'b0, 2'b00, 2'b10, 2'b01},  // R2 B off
    {1'b0, 2'b11, 2'b01, 2'b11},  // R3 A conflict holds 1, B on
    {1'b1, 2'b00, 2'b11, 2'b00},  // R2 both off
    {1'b0, 2'b10, 2'b10, 2'b00},  // R3 B conflict holds 0
    {1'b0, 2'b10, 2'b00, 2'b10},  // R11 single B passes
    {1'b1, 2'b00, 2'b00, 2'b10}   // R10 single B passes with interlock
  };

  task automatic check(input string req, input logic [1:0] exp);
    n_chk++;
    if (drive !== exp) begin
      n_err++;
      $display("FAIL %s: drive=%b expected=%b", req, drive, exp);
    end
  endtask

  // called at a negedge; strobes last exactly one posedge
  task automatic strobe(input logic ex, input logic [1:0] s, input logic [1:0] c);
    mode_excl = ex;
    set_pulse = s;
    clr_pulse = c;
    @(negedge clk);
    set_pulse = 2'b00;
    clr_pulse = 2'b00;
  endtask

  task automatic finish_run();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: run hung, actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; supply_ok = 1'b0; mode_excl = 1'b0;
    set_pulse = 2'b00; clr_pulse = 2'b00;
    repeat (3) @(negedge clk);
    check("R7 in reset", 2'b00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    supply_ok = 1'b1;
    @(negedge clk);
    check("R7 after release", 2'b00);

    for (int i = 0; i < 10; i++) begin
      strobe(VEC[i][6], VEC[i][5:4], VEC[i][3:2]);
      check($sformatf("vector %0d (R1 R2 R3 R10 R11)", i), VEC[i][1:0]);
    end

    // supply lockout, latch keeps tracking
    supply_ok = 1'b0;
    strobe(1'b0, 2'b11, 2'b00);
    check("R8 lockout", 2'b00);
    supply_ok = 1'b1;
    @(negedge clk);
    check("R9 release", 2'b11);

    // watchdog: A on, B off at edge e
    strobe(1'b0, 2'b01, 2'b10);
    repeat (TO - 1) @(negedge clk);
    check("R4 last valid edge", 2'b01);
    @(negedge clk);
    check("R4 timeout", 2'b00);
    strobe(1'b0, 2'b01, 2'b01);
    check("R6 conflict after timeout", 2'b00);
    strobe(1'b0, 2'b01, 2'b00);
    check("R6 restore", 2'b01);

    // restart: second strobe midway, check past the first deadline
    repeat (TO / 2) @(negedge clk);
    strobe(1'b0, 2'b01, 2'b00);
    repeat (TO - 1) @(negedge clk);
    check("R5 restarted count", 2'b01);
    @(negedge clk);
    check("R5 expiry after restart", 2'b00);

    done = 1'b1;
    finish_run();
  end

endmodule